// File: doc/BRIEF.md
# Double-Buffered Serial Output Shifter

This block turns 16-bit words written by a real-time core into a serial bit stream. It drives one data pin and a clock pin that it generates itself. The block watches the core's 32-bit output register value. The low half of that value is the payload, and three upper bits act as commands: two of them copy the payload into one of two holding buffers, and the third lets the stream run.

While the stream runs, the block sends one buffer most significant bit first. It then moves to the other buffer with no idle bit cell in between. A status output shows which buffer is being read. Software can therefore refill the idle buffer and keep the stream going without a break.

The bit rate is set by two fractional dividers in series. Each divider takes a 5-bit code and divides by any value from 1 to 16 in steps of one half. Each bit cell lasts two ticks of the second divider: one tick with the clock low, then one tick with the clock high. Data changes only on the rising clock edge.

Top module: `sso_serial_out`

## Requirements
- R1: During reset and at the first falling core-clock edge after reset is released, `ser_clk` is 0, `ser_data` is 0 and `active_buf` is 0, provided the enable bit is clear.
- R2: At every core-clock edge where `out_word[29]` is 1, buffer A takes `out_word[15:0]`. At every edge where `out_word[30]` is 1, buffer B takes it. The two loads are independent and may both happen in one cycle.
- R3: `out_word[31]` = 1 enables shifting. A load bit may be set in the same word as the enable bit without stopping the stream.
- R4: After reset the first buffer sent is A. Each buffer goes out most significant bit first. After bit 0 of a buffer, the next bit cell carries bit 15 of the other buffer, with no idle cell between them.
- R5: `ser_data` changes only at a rising edge of `ser_clk`. `ser_clk` changes only on a tick of the divider chain.
- R6: A divider code c gives a divisor of 1 + c/2. Codes above 30 act as 30. With codes c1 and c2 and a continuous stream, 16 rising edges of `ser_clk` take exactly 8·(c1+2)·(c2+2) core cycles.
- R7: `active_buf` (0 = A, 1 = B) names the buffer that supplies the next bit. It toggles at the rising `ser_clk` edge that sends bit 0 of the current buffer.
- R8: When the enable bit is cleared, the bit on the pin completes its high phase. After that, `ser_clk` stays low, no further rising edge occurs, and `ser_data` holds the last bit sent.
- R9: When the enable bit is set again, shifting resumes with the next unsent bit of the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_word | input | 32 | Core output register value: [15:0] payload, [29] load A, [30] load B, [31] enable |
| div_code_a | input | 5 | First divider code, divisor 1 + code/2 |
| div_code_b | input | 5 | Second divider code, divisor 1 + code/2 |
| ser_data | output | 1 | Serial data pin |
| ser_clk | output | 1 | Generated serial clock pin |
| active_buf | output | 1 | Buffer currently being shifted (0 = A, 1 = B) |

## Verification
The hardest case to reach is a buffer swap in which the idle buffer was refilled while its partner was still shifting. The new word must follow on without a gap, and the refill must not disturb the word on the pin. To reach it, the bench waits until `active_buf` reports B and then writes one word that holds both a load of A and the enable bit. The following 16 bits must then carry the fresh content of A. A second hard case is stopping halfway through a bit cell. The bench clears the enable bit right after a rising edge, confirms that the clock falls and stays low with the data held, and then re-enables and checks that the stream picks up at the next bit.

// File: rtl/sso_pkg.sv
package sso_pkg;
  localparam int CODE_W   = 5;
  localparam int CODE_MAX = 30;
  localparam int ACC_W    = 6;

  // Numerator of a half-step divisor: divisor = num/2, num = code + 2.
  function automatic logic [ACC_W-1:0] div_num(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;
    return ACC_W'(c) + ACC_W'(2);
  endfunction

  // Next accumulator value after one step; kept below the numerator.
  function automatic logic [ACC_W-1:0] acc_next(input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] num);
    logic [ACC_W-1:0] s;
    s = acc + ACC_W'(2);
    if (s < num) return s;
    return ((s - num) < num) ? (s - num) : '0;
  endfunction
endpackage

// File: rtl/sso_frac_div.sv
module sso_frac_div
  import sso_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] lim;
  logic             wrap;

  always_comb begin
    lim  = div_num(code);
    wrap = (acc_q + ACC_W'(2)) >= lim;
    tick = step_en && wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (step_en) acc_q <= acc_next(acc_q, lim);
  end

  // R6: the phase accumulator never reaches the divisor numerator
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(code) |-> (acc_q < lim));
endmodule

// File: rtl/sso_shadow_bank.sv
module sso_shadow_bank #(
  parameter int N_BUF = 2,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_BUF-1:0]         ld,
  input  logic [W-1:0]             din,
  output logic [N_BUF-1:0][W-1:0]  q
);
  for (genvar g = 0; g < N_BUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)     q[g] <= '0;
      else if (ld[g]) q[g] <= din;
    end

    // R2
    hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld[g] |=> $stable(q[g]));
  end
endmodule

// File: rtl/sso_shifter.sv
module sso_shifter #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic [1:0][W-1:0] bufs,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              sel
);
  localparam int IDX_W = $clog2(W);

  logic [IDX_W-1:0] idx_q;
  logic             launch;
  logic             fall;
  logic             last_bit;
  logic             cur_bit;

  assign launch   = tick && !ser_clk && en;
  assign fall     = tick && ser_clk;
  assign last_bit = (idx_q == IDX_W'(W - 1));
  assign cur_bit  = bufs[sel][IDX_W'(W - 1) - idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      sel      <= 1'b0;
      idx_q    <= '0;
    end else if (fall) begin
      ser_clk <= 1'b0;
    end else if (launch) begin
      ser_clk  <= 1'b1;
      ser_data <= cur_bit;
      if (last_bit) begin
        idx_q <= '0;
        sel   <= ~sel;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R5
  data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ser_clk) |-> $stable(ser_data));
  // R5
  clk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ser_clk));
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ser_clk) |=> !ser_clk);
  // R7
  swap_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> $rose(ser_clk));
endmodule

// File: rtl/sso_serial_out.sv
module sso_serial_out
  import sso_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 16,
  parameter int LDA_BIT = 29,
  parameter int LDB_BIT = 30,
  parameter int EN_BIT  = 31,
  parameter int N_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] out_word,
  input  logic [CODE_W-1:0] div_code_a,
  input  logic [CODE_W-1:0] div_code_b,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              active_buf
);
  logic [N_STAGE-1:0][CODE_W-1:0] codes;
  logic [N_STAGE:0]               tick_chain;
  logic [1:0][DATA_W-1:0]         bufs;
  logic                           bit_tick;
  logic                           unused_word_bits;

  assign codes         = {div_code_b, div_code_a};
  assign tick_chain[0] = 1'b1;
  assign bit_tick      = tick_chain[N_STAGE];
  assign unused_word_bits = ^out_word[LDA_BIT-1:DATA_W];

  for (genvar g = 0; g < N_STAGE; g++) begin : g_div
    sso_frac_div u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (tick_chain[g]),
      .code    (codes[g]),
      .tick    (tick_chain[g+1])
    );
  end

  sso_shadow_bank #(.N_BUF(2), .W(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    ({out_word[LDB_BIT], out_word[LDA_BIT]}),
    .din   (out_word[DATA_W-1:0]),
    .q     (bufs)
  );

  sso_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .en       (out_word[EN_BIT]),
    .bufs     (bufs),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .sel      (active_buf)
  );
endmodule

// File: tb/test_sso_serial_out.sv
module test_sso_serial_out;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] LDA = 32'h2000_0000;
  localparam logic [31:0] LDB = 32'h4000_0000;
  localparam int NV = 5;
  // {code_a, code_b, word A, word B, word C written after the first swap}
  localparam logic [63:0] VEC [0:NV-1] = '{
    {8'd0,  8'd0, 16'hA5C3, 16'h0FF1, 16'h8001},
    {8'd1,  8'd0, 16'h1234, 16'hFEDC, 16'h5555},
    {8'd3,  8'd5, 16'hBEEF, 16'h0001, 16'h7FFE},
    {8'd31, 8'd0, 16'hFFFF, 16'h0000, 16'h9A6B},
    {8'd30, 8'd2, 16'h3C3C, 16'hC3C3, 16'h6DB6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] out_word = '0;
  logic [4:0]  div_code_a = '0;
  logic [4:0]  div_code_b = '0;
  logic        ser_data, ser_clk, active_buf;

  int n_chk = 0, n_err = 0, cyc = 0, cap_n = 0, bad_change = 0;
  logic cap [0:63];
  logic sa  [0:63];
  int   rc  [0:63];
  logic prev_clk = 1'b0, prev_data = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sso_serial_out i_sso_serial_out (
    .clk(clk), .rst_n(rst_n), .out_word(out_word),
    .div_code_a(div_code_a), .div_code_b(div_code_b),
    .ser_data(ser_data), .ser_clk(ser_clk), .active_buf(active_buf)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_clk && !prev_clk) begin
        if (cap_n < 64) begin
          cap[cap_n] = ser_data; sa[cap_n] = active_buf; rc[cap_n] = cyc;
        end
        cap_n++;
      end else if (ser_data != prev_data) begin
        bad_change++;
      end
    end
    prev_clk = ser_clk; prev_data = ser_data;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] ca, input logic [4:0] cb);
    out_word = '0; div_code_a = ca; div_code_b = cb; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cap_n = 0; bad_change = 0;
    // R1
    chk({ser_clk, ser_data, active_buf} == 3'b000, "R1 reset state",
        {ser_clk, ser_data, active_buf}, 0);
  endtask

  task automatic pulse(input logic [31:0] w, input logic [31:0] after);
    out_word = w;
    @(negedge clk);
    out_word = after;
  endtask

  task automatic wait_caps(input int n);
    while (cap_n < n) @(negedge clk);
  endtask

  function automatic logic [15:0] word_at(input int base);
    logic [15:0] w = '0;
    for (int i = 0; i < 16; i++) w = {w[14:0], cap[base+i]};
    return w;
  endfunction

  function automatic int exp_cycles(input int ca, input int cb);
    real da = 1.0 + ((ca > 30) ? 30 : ca) / 2.0;
    real db = 1.0 + ((cb > 30) ? 30 : cb) / 2.0;
    return int'(32.0 * da * db);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  ca = VEC[v][63:56];
      logic [7:0]  cb = VEC[v][55:48];
      logic [15:0] wa = VEC[v][47:32];
      logic [15:0] wb = VEC[v][31:16];
      logic [15:0] wc = VEC[v][15:0];
      int ec;
      do_reset(ca[4:0], cb[4:0]);
      pulse(LDA | 32'(wa), '0);
      pulse(LDB | 32'(wb) | 32'h0001_0000, '0);
      out_word = EN;
      while (!active_buf) @(negedge clk);
      // R3: load A together with the enable bit while B shifts
      pulse(EN | LDA | 32'(wc), EN);
      wait_caps(49);
      out_word = '0;
      // R4, R2
      chk(word_at(0)  == wa, "R4 first word A",  word_at(0),  wa);
      chk(word_at(16) == wb, "R4 second word B", word_at(16), wb);
      chk(word_at(32) == wc, "R2 refilled A",    word_at(32), wc);
      // R6
      ec = exp_cycles(int'(ca), int'(cb));
      chk(rc[16] - rc[0] == ec, "R6 word period A", rc[16] - rc[0], ec);
      chk(rc[32] - rc[16] == ec, "R6 word period B", rc[32] - rc[16], ec);
      chk(rc[48] - rc[32] == ec, "R4 gapless swap", rc[48] - rc[32], ec);
      // R7
      chk({sa[14], sa[15], sa[30], sa[31]} == 4'b0110, "R7 swap flag",
          {sa[14], sa[15], sa[30], sa[31]}, 4'b0110);
      // R5
      chk(bad_change == 0, "R5 data moves only on rise", bad_change, 0);
    end

    // R8 / R9: stop mid-word and resume
    do_reset(5'd2, 5'd2);
    pulse(LDA | 32'h0000_B2D4, '0);
    out_word = EN;
    wait_caps(3);
    out_word = '0;
    repeat (120) @(negedge clk);
    chk(cap_n == 3, "R8 no rise after disable", cap_n, 3);
    chk(ser_clk == 1'b0, "R8 clock idles low", ser_clk, 0);
    chk(ser_data == cap[2], "R8 data holds last bit", ser_data, cap[2]);
    out_word = EN;
    wait_caps(17);
    out_word = '0;
    chk(word_at(0) == 16'hB2D4, "R9 resume next bit", word_at(0), 16'hB2D4);
    chk(sa[15] == 1'b1 && sa[14] == 1'b0, "R7 swap after resume", {sa[14], sa[15]}, 2'b01);
    chk(bad_change == 0, "R5 data stable through stop", bad_change, 0);

    // R2: both buffers loaded by one word
    do_reset(5'd0, 5'd1);
    pulse(LDA | LDB | 32'h0000_4E71, '0);
    out_word = EN;
    wait_caps(32);
    out_word = '0;
    chk(word_at(0) == 16'h4E71 && word_at(16) == 16'h4E71, "R2 dual load",
        {word_at(0), word_at(16)}, 32'h4E714E71);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule